// File: doc/BRIEF.md
# Mode-Controlled Secondary Cache Controller

This block is a direct-mapped secondary cache placed between a processor request port and a line-oriented memory port. It holds sixteen lines of four 32-bit words, each line with a tag, a valid bit and a dirty bit. Four configuration inputs select how it behaves: an enable bit, an initialize bit, a directory-freeze bit and a write-policy bit (0 = write-through, 1 = write-back for write hits).

The configuration is decoded into four operating modes: off, initialize, normal and frozen. Each mode grants a set of permissions: line fill, castout of a dirty victim, serving read hits, updating on write hits and marking lines dirty. The mode is sampled when a processor request is accepted and stays fixed until that request finishes. Software uses initialize mode to load the whole cache with fresh lines before it turns the cache on. Before it turns a write-back cache off, software must write every dirty line back to memory by reading a conflicting address for each one.

The processor side uses a valid/ready handshake: `cpuValid` and the request fields are held until `cpuReady` pulses for one cycle. The memory side carries one word per beat. `memReq` and the beat address are held until `memAck`. A line transfer takes four beats, in ascending word order from the line base.

Top module: `secCacheTop`

## Requirements
- R1: After reset `cpuReady` and `memReq` are 0 and every line is invalid, so the first cached read always fetches a full line.
- R2: The cache is off when enable and initialize are both 0, and also when both are 1. In that state every read and every write makes exactly one memory beat at the request address, and the cache is not touched.
- R3: In initialize mode (enable 0, initialize 1, freeze ignored) every read fetches a full line (4 read beats), even when the tag matches. It never writes back a dirty victim, and the new line is left valid and clean.
- R4: In initialize mode a write hit updates the cached word and is also written to memory as one beat, whatever the write-policy bit says.
- R5: In normal mode (enable 1, initialize 0, freeze 0) a read hit returns the cached word with no memory traffic.
- R6: In normal mode a read miss fetches the line in 4 beats at addresses base+0, +4, +8, +12 and returns the requested word. The line becomes valid and clean.
- R7: In normal mode, when a read misses on a valid dirty line, the controller first writes the 4 words of that line back to memory at the victim's own address, then fetches the new line.
- R8: In normal mode, a write hit with write-policy 1 updates the cache, makes no memory beat and marks the line dirty. With write-policy 0 the write hit updates the cache and makes one memory write.
- R9: In frozen mode (enable 1, initialize 0, freeze 1) a read hit is served with no memory traffic. A read miss makes one single-word memory read, allocates nothing (a repeat of the same miss reads memory again) and never causes a castout.
- R10: In frozen mode a write hit updates the cached word. With write-policy 1 it makes no memory beat and marks the line dirty; with write-policy 0 it makes one memory write.
- R11: A write miss in any mode makes one memory write and allocates no line.
- R12: Each read returns the value most recently written to that address, as long as dirty lines are written back before leaving normal/frozen operation and the cache is re-initialized before re-entering it.
- R13: `cpuReady` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Cache enable configuration bit |
| cfgInit | input | 1 | Initialize-mode configuration bit |
| cfgFreeze | input | 1 | Freeze the directory (no allocation or eviction) |
| cfgWriteBack | input | 1 | Write-hit policy: 0 write-through, 1 write-back |
| cpuValid | input | 1 | Processor request valid, held until cpuReady |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuAddr | input | ADDR_W | Byte address: [3:2] word, [7:4] index, upper bits tag |
| cpuWrite | input | 1 | 1 = write request, 0 = read request |
| cpuWdata | input | DATA_W | Write data |
| cpuRdata | output | DATA_W | Read data, valid while cpuReady is high |
| memReq | output | 1 | Memory beat request, held until memAck |
| memWrite | output | 1 | 1 = memory write beat |
| memAddr | output | ADDR_W | Byte address of the current beat |
| memWdata | output | DATA_W | Write data of the current beat |
| memRdata | input | DATA_W | Read data, valid with memAck |
| memAck | input | 1 | Beat acknowledge |

## Verification
The hardest situation to reach from the ports is a castout: it needs a write-back write hit in normal or frozen mode, followed by a normal-mode read miss on the same index with a different tag, and no mode change in between that would skip or discard the write-back. A directed sequence builds exactly this case. The random phase then changes modes with a fixed seed, keeps the addresses in four tags so that index collisions are frequent, and runs the required write-back and re-initialize sweeps at each change of operating class, so dirty victims keep appearing under changing policies. A bench model of tags, valid and dirty bits predicts the exact read and write beat count of each request, and a shadow memory predicts every read value.

// File: rtl/secCachePkg.sv
`timescale 1ns/1ps
package secCachePkg;

  typedef enum logic [1:0] {
    MODE_OFF,
    MODE_INIT,
    MODE_NORMAL,
    MODE_FROZEN
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_SINGLE,
    ST_CAST,
    ST_FILL,
    ST_DONE
  } state_e;

  // permissions granted by the decoded mode
  typedef struct packed {
    logic fill;
    logic castout;
    logic hitServe;
    logic writeUpdate;
    logic markDirty;
  } perm_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;
    logic rspCache;
    logic rspMem;
    logic wordWrite;
    logic setDirty;
    logic fillBeat;
    logic fillDone;
    logic addrCast;
    logic addrLine;
  } strobe_t;

endpackage

// File: rtl/secCacheModeDecode.sv
`timescale 1ns/1ps
module secCacheModeDecode
  import secCachePkg::*;
(
  input  logic  cfgEnable,
  input  logic  cfgInit,
  input  logic  cfgFreeze,
  input  logic  cfgWriteBack,
  output mode_e mode,
  output perm_t perm
);

  always_comb begin
    if (cfgEnable && !cfgInit) begin
      mode = cfgFreeze ? MODE_FROZEN : MODE_NORMAL;
    end else if (!cfgEnable && cfgInit) begin
      mode = MODE_INIT;
    end else begin
      mode = MODE_OFF; // includes the invalid enable+init combination
    end
  end

  always_comb begin
    perm = '0;
    case (mode)
      MODE_INIT: begin
        perm.fill        = 1'b1;
        perm.writeUpdate = 1'b1;
      end
      MODE_NORMAL: begin
        perm.fill        = 1'b1;
        perm.castout     = 1'b1;
        perm.hitServe    = 1'b1;
        perm.writeUpdate = 1'b1;
        perm.markDirty   = cfgWriteBack;
      end
      MODE_FROZEN: begin
        perm.hitServe    = 1'b1;
        perm.writeUpdate = 1'b1;
        perm.markDirty   = cfgWriteBack;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/secCacheCtrl.sv
`timescale 1ns/1ps
module secCacheCtrl
  import secCachePkg::*;
#(
  parameter  int WORDS     = 4,
  localparam int WORD_BITS = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuValid,
  input  mode_e                mode,
  input  perm_t                perm,
  input  logic                 hit,
  input  logic                 victimDirty,
  input  logic                 reqWrite,
  input  logic                 memAck,
  output strobe_t              strb,
  output logic [WORD_BITS-1:0] beat,
  output logic                 memReq,
  output logic                 memWrite,
  output logic                 cpuReady
);

  state_e state, nxt;
  perm_t  permQ;
  mode_e  modeQ;
  logic   lastBeat;

  assign lastBeat = (beat == WORD_BITS'(WORDS - 1));

  always_comb begin
    strb     = '0;
    nxt      = state;
    memReq   = 1'b0;
    memWrite = 1'b0;
    cpuReady = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cpuValid) begin
          strb.latch = 1'b1;
          nxt        = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (!reqWrite) begin
          if (permQ.hitServe && hit) begin
            strb.rspCache = 1'b1;
            nxt           = ST_DONE;
          end else if (permQ.fill) begin
            nxt = (permQ.castout && victimDirty) ? ST_CAST : ST_FILL;
          end else begin
            nxt = ST_SINGLE;
          end
        end else if (permQ.writeUpdate && hit) begin
          strb.wordWrite = 1'b1;
          if (permQ.markDirty) begin
            strb.setDirty = 1'b1;
            nxt           = ST_DONE;
          end else begin
            nxt = ST_SINGLE;
          end
        end else begin
          nxt = ST_SINGLE;
        end
      end
      ST_SINGLE: begin
        memReq   = 1'b1;
        memWrite = reqWrite;
        if (memAck) begin
          strb.rspMem = !reqWrite;
          nxt         = ST_DONE;
        end
      end
      ST_CAST: begin
        memReq        = 1'b1;
        memWrite      = 1'b1;
        strb.addrCast = 1'b1;
        if (memAck && lastBeat) nxt = ST_FILL;
      end
      ST_FILL: begin
        memReq        = 1'b1;
        strb.addrLine = 1'b1;
        if (memAck) begin
          strb.fillBeat = 1'b1;
          if (lastBeat) begin
            strb.fillDone = 1'b1;
            nxt           = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        cpuReady = 1'b1;
        nxt      = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beat  <= '0;
      permQ <= '0;
      modeQ <= MODE_OFF;
    end else begin
      state <= nxt;
      if (strb.latch) begin
        permQ <= perm;
        modeQ <= mode;
      end
      if (state == ST_LOOK) begin
        beat <= '0;
      end else if ((state == ST_CAST || state == ST_FILL) && memAck) begin
        beat <= beat + 1'b1;
      end
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady); // R13

  AST_CAST_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAST) |-> (modeQ == MODE_NORMAL)); // R3

endmodule

// File: rtl/secCacheDatapath.sv
`timescale 1ns/1ps
module secCacheDatapath
  import secCachePkg::*;
#(
  parameter  int ADDR_W    = 16,
  parameter  int DATA_W    = 32,
  parameter  int LINES     = 16,
  parameter  int WORDS     = 4,
  localparam int WORD_BITS = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [WORD_BITS-1:0] beat,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic                 cpuWrite,
  input  logic [DATA_W-1:0]    cpuWdata,
  input  logic [DATA_W-1:0]    memRdata,
  output logic                 reqWrite,
  output logic                 hit,
  output logic                 victimDirty,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  output logic [DATA_W-1:0]    cpuRdata
);

  localparam int BYTE_BITS = $clog2(DATA_W / 8);
  localparam int IDX_BITS  = $clog2(LINES);
  localparam int TAG_W     = ADDR_W - IDX_BITS - WORD_BITS - BYTE_BITS;

  logic [ADDR_W-1:0]    reqAddr;
  logic [DATA_W-1:0]    reqWdata;
  logic [DATA_W-1:0]    rspData;
  logic [TAG_W-1:0]     tagArr  [LINES];
  logic [DATA_W-1:0]    dataArr [LINES][WORDS];
  logic [LINES-1:0]     validArr;
  logic [LINES-1:0]     dirtyArr;

  logic [TAG_W-1:0]     reqTag;
  logic [IDX_BITS-1:0]  idx;
  logic [WORD_BITS-1:0] word;

  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];
  assign idx    = reqAddr[BYTE_BITS+WORD_BITS +: IDX_BITS];
  assign word   = reqAddr[BYTE_BITS +: WORD_BITS];

  assign hit         = validArr[idx] && (tagArr[idx] == reqTag);
  assign victimDirty = validArr[idx] && dirtyArr[idx];
  assign cpuRdata    = rspData;

  always_comb begin
    if (strb.addrCast) begin
      memAddr = {tagArr[idx], idx, beat, {BYTE_BITS{1'b0}}};
    end else if (strb.addrLine) begin
      memAddr = {reqTag, idx, beat, {BYTE_BITS{1'b0}}};
    end else begin
      memAddr = reqAddr;
    end
    memWdata = strb.addrCast ? dataArr[idx][beat] : reqWdata;
  end

  // request capture, line state and response register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWrite <= 1'b0;
      reqWdata <= '0;
      rspData  <= '0;
      validArr <= '0;
      dirtyArr <= '0;
    end else begin
      if (strb.latch) begin
        reqAddr  <= cpuAddr;
        reqWrite <= cpuWrite;
        reqWdata <= cpuWdata;
      end
      if (strb.fillDone) begin
        validArr[idx] <= 1'b1;
        dirtyArr[idx] <= 1'b0;
      end
      if (strb.setDirty) dirtyArr[idx] <= 1'b1;
      if (strb.rspCache) begin
        rspData <= dataArr[idx][word];
      end else if (strb.rspMem) begin
        rspData <= memRdata;
      end else if (strb.fillBeat && (beat == word)) begin
        rspData <= memRdata;
      end
    end
  end

  // storage arrays: no reset, qualified by validArr
  always_ff @(posedge clk) begin
    if (strb.fillBeat)  dataArr[idx][beat] <= memRdata;
    if (strb.wordWrite) dataArr[idx][word] <= reqWdata;
    if (strb.fillDone)  tagArr[idx]        <= reqTag;
  end

  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillDone |=> (validArr[$past(idx)] && !dirtyArr[$past(idx)])); // R6

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    ((dirtyArr & ~validArr) == '0)); // R8

endmodule

// File: rtl/secCacheTop.sv
`timescale 1ns/1ps
module secCacheTop
  import secCachePkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgInit,
  input  logic              cfgFreeze,
  input  logic              cfgWriteBack,
  input  logic              cpuValid,
  output logic              cpuReady,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);

  localparam int WORD_BITS = $clog2(WORDS);

  mode_e                mode;
  perm_t                perm;
  strobe_t              strb;
  logic [WORD_BITS-1:0] beat;
  logic                 hit;
  logic                 victimDirty;
  logic                 reqWrite;

  secCacheModeDecode u_decode (
    .cfgEnable   (cfgEnable),
    .cfgInit     (cfgInit),
    .cfgFreeze   (cfgFreeze),
    .cfgWriteBack(cfgWriteBack),
    .mode        (mode),
    .perm        (perm)
  );

  secCacheCtrl #(.WORDS(WORDS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuValid   (cpuValid),
    .mode       (mode),
    .perm       (perm),
    .hit        (hit),
    .victimDirty(victimDirty),
    .reqWrite   (reqWrite),
    .memAck     (memAck),
    .strb       (strb),
    .beat       (beat),
    .memReq     (memReq),
    .memWrite   (memWrite),
    .cpuReady   (cpuReady)
  );

  secCacheDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LINES (LINES),
    .WORDS (WORDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .beat       (beat),
    .cpuAddr    (cpuAddr),
    .cpuWrite   (cpuWrite),
    .cpuWdata   (cpuWdata),
    .memRdata   (memRdata),
    .reqWrite   (reqWrite),
    .hit        (hit),
    .victimDirty(victimDirty),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .cpuRdata   (cpuRdata)
  );

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite))); // R6

endmodule

// File: tb/secCacheTop_tb.sv
`timescale 1ns/1ps
module secCacheTop_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgEnable, cfgInit, cfgFreeze, cfgWriteBack;
  logic        cpuValid, cpuReady, cpuWrite;
  logic [15:0] cpuAddr;
  logic [31:0] cpuWdata, cpuRdata;
  logic        memReq, memWrite, memAck;
  logic [15:0] memAddr;
  logic [31:0] memWdata, memRdata;

  always #2 clk = ~clk;

  secCacheTop u_dut (
    .clk(clk), .rstN(rstN),
    .cfgEnable(cfgEnable), .cfgInit(cfgInit), .cfgFreeze(cfgFreeze), .cfgWriteBack(cfgWriteBack),
    .cpuValid(cpuValid), .cpuReady(cpuReady), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  int          checks = 0;
  int          fails  = 0;
  int          rdBeats, wrBeats;
  logic [15:0] rdLog [4];
  logic [31:0] memArr [256];
  logic [31:0] golden [256];
  logic [1:0]  mTag   [16];
  logic [15:0] mValid, mDirty;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: one beat acknowledged per request, random stalls
  initial begin
    memAck = 1'b0;
    memRdata = '0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
      end else if (memReq && ($urandom_range(0, 2) != 0)) begin
        memAck = 1'b1;
        if (memAddr[15:10] != 6'd0) check("R2", "memory address range", {16'd0, memAddr}, {22'd0, memAddr[9:0]});
        if (memWrite) begin
          memArr[memAddr[9:2]] = memWdata;
          wrBeats++;
        end else begin
          memRdata = memArr[memAddr[9:2]];
          if (rdBeats < 4) rdLog[rdBeats] = memAddr;
          rdBeats++;
        end
      end
    end
  end

  function automatic int curMode();
    if (cfgEnable && !cfgInit) return cfgFreeze ? 3 : 2;
    if (!cfgEnable && cfgInit) return 1;
    return 0;
  endfunction

  task automatic doAccess(input logic wr, input logic [15:0] addr, input logic [31:0] wd, output logic [31:0] rd);
    rdBeats = 0;
    wrBeats = 0;
    @(negedge clk);
    cpuValid = 1'b1;
    cpuWrite = wr;
    cpuAddr  = addr;
    cpuWdata = wd;
    forever begin
      @(negedge clk);
      if (cpuReady) break;
    end
    rd = cpuRdata;
    cpuValid = 1'b0;
    @(negedge clk);
    check("R13", "ready pulse width", {31'd0, cpuReady}, 32'd0);
  endtask

  // one request, with beat counts and data predicted by the model
  task automatic access(input logic wr, input logic [15:0] addr, input logic [31:0] wd);
    int          m;
    int          expR;
    int          expW;
    logic [3:0]  ix;
    logic [1:0]  tg;
    logic        h;
    string       req;
    logic [31:0] rd;
    m = curMode();
    ix = addr[7:4];
    tg = addr[9:8];
    h = mValid[ix] && (mTag[ix] == tg);
    expR = 0;
    expW = 0;
    if (!wr) begin
      case (m)
        0: begin expR = 1; req = "R2"; end
        1: begin
          expR = 4; req = "R3";
          mValid[ix] = 1'b1; mTag[ix] = tg; mDirty[ix] = 1'b0;
        end
        2: begin
          if (h) begin
            req = "R5";
          end else begin
            if (mValid[ix] && mDirty[ix]) begin expW = 4; req = "R7"; end
            else req = "R6";
            expR = 4;
            mValid[ix] = 1'b1; mTag[ix] = tg; mDirty[ix] = 1'b0;
          end
        end
        default: begin req = "R9"; expR = h ? 0 : 1; end
      endcase
    end else begin
      if (m != 0 && h) begin
        if (m >= 2 && cfgWriteBack) begin
          mDirty[ix] = 1'b1;
          req = (m == 3) ? "R10" : "R8";
        end else begin
          expW = 1;
          req = (m == 1) ? "R4" : ((m == 3) ? "R10" : "R8");
        end
      end else begin
        expW = 1;
        req = (m == 0) ? "R2" : "R11";
      end
      golden[addr[9:2]] = wd;
    end
    doAccess(wr, addr, wd, rd);
    check(req, "read beats", rdBeats, expR);
    check(req, "write beats", wrBeats, expW);
    if (!wr) check("R12", "read data", rd, golden[addr[9:2]]);
  endtask

  task automatic flushDirty();
    cfgEnable = 1'b1; cfgInit = 1'b0; cfgFreeze = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (mValid[i] && mDirty[i]) access(1'b0, {6'd0, mTag[i] ^ 2'd1, 4'(i), 4'd0}, 32'd0);
    end
  endtask

  task automatic sweepInit();
    cfgEnable = 1'b0; cfgInit = 1'b1; cfgFreeze = 1'($urandom_range(0, 1));
    for (int i = 0; i < 16; i++) begin
      access(1'b0, {6'd0, 2'($urandom_range(0, 3)), 4'(i), 2'($urandom_range(0, 3)), 2'd0}, 32'd0);
    end
  endtask

  task automatic setMode(input logic en, input logic ini, input logic frz, input logic wb);
    logic toCached;
    toCached = en && !ini;
    if (curMode() >= 2 && !toCached) flushDirty();
    if (curMode() < 2 && toCached) sweepInit();
    cfgEnable = en; cfgInit = ini; cfgFreeze = frz; cfgWriteBack = wb;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    cfgEnable = 0; cfgInit = 0; cfgFreeze = 0; cfgWriteBack = 0;
    cpuValid = 0; cpuWrite = 0; cpuAddr = '0; cpuWdata = '0;
    mValid = '0; mDirty = '0;
    for (int i = 0; i < 16; i++) mTag[i] = 2'd0;
    for (int i = 0; i < 256; i++) begin
      memArr[i] = 32'h5A00_0000 + i * 32'h0001_0101;
      golden[i] = memArr[i];
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "cpuReady after reset", {31'd0, cpuReady}, 32'd0);
    check("R1", "memReq after reset", {31'd0, memReq}, 32'd0);

    // normal write-back mode, caches start empty
    cfgEnable = 1'b1; cfgWriteBack = 1'b1;
    access(1'b0, 16'h0008, 32'd0);
    check("R1", "first read fetches a line", rdBeats, 4);
    for (int i = 0; i < 4; i++) check("R6", "fill beat address", {16'd0, rdLog[i]}, 32'(i * 4));
    access(1'b0, 16'h000C, 32'd0);                 // R5 hit
    access(1'b1, 16'h0008, 32'hDEAD_0001);         // R8 write-back hit
    check("R8", "memory untouched by write-back hit", memArr[2], 32'h5A00_0000 + 2 * 32'h0001_0101);
    access(1'b0, 16'h0108, 32'd0);                 // R7 castout then fill
    check("R7", "victim word written back", memArr[2], 32'hDEAD_0001);
    access(1'b0, 16'h0008, 32'd0);                 // R12 data comes back
    cfgWriteBack = 1'b0;
    access(1'b1, 16'h0004, 32'hBEEF_0002);         // R8 write-through hit
    access(1'b1, 16'h0224, 32'hCAFE_0003);         // R11 write miss
    access(1'b0, 16'h0224, 32'd0);                 // line not allocated by the write: R11 fill
    check("R11", "write miss did not allocate", rdBeats, 4);

    // frozen directory
    cfgFreeze = 1'b1; cfgWriteBack = 1'b1;
    access(1'b0, 16'h0310, 32'd0);                 // R9 miss
    access(1'b0, 16'h0310, 32'd0);                 // R9 no allocation
    access(1'b0, 16'h0004, 32'd0);                 // R9 hit
    access(1'b1, 16'h000C, 32'h1234_0004);         // R10 write-back hit
    access(1'b0, 16'h000C, 32'd0);

    // initialize mode with write-back selected
    setMode(1'b0, 1'b1, 1'b0, 1'b1);
    access(1'b0, 16'h000C, 32'd0);                 // R3 fill
    access(1'b0, 16'h000C, 32'd0);                 // R3 forced miss again
    access(1'b1, 16'h0008, 32'h7777_0005);         // R4 forced write-through
    // invalid combination and plain off
    setMode(1'b1, 1'b1, 1'b0, 1'b1);
    access(1'b0, 16'h0008, 32'd0);                 // R2
    access(1'b1, 16'h0008, 32'h8888_0006);         // R2
    setMode(1'b0, 1'b0, 1'b0, 1'b1);
    access(1'b0, 16'h0008, 32'd0);                 // R2

    // constrained random phases
    for (int p = 0; p < 40; p++) begin
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: setMode(1'b0, 1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        1: setMode(1'b1, 1'b1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        2: setMode(1'b0, 1'b1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        3, 4: setMode(1'b1, 1'b0, 1'b0, 1'($urandom_range(0, 1)));
        default: setMode(1'b1, 1'b0, 1'b1, 1'($urandom_range(0, 1)));
      endcase
      for (int k = 0; k < 15; k++) begin
        logic [15:0] a;
        a = {6'd0, 2'($urandom_range(0, 3)), 2'd0, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'd0};
        access(1'($urandom_range(0, 2) == 0), a, $urandom);
      end
    end
    setMode(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 256; i++) begin
      if (memArr[i] !== golden[i]) check("R12", "final memory image", memArr[i], golden[i]);
    end
    checks++;

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule